// File: doc/BRIEF.md
# Latched Angle Output Bus Interface

This block connects a continuously tracking angle counter to a host data bus that is one byte wide. A holding register follows the counter on every clock while the active-low hold input is high. When the hold input is low, the register keeps its value, so the host can read both bytes of one stable word. The counter is an input to the block and keeps running during a hold. After the hold is released, the register shows the counter's latest value.

The host reads the word one byte at a time. It uses two active-low byte enables. One places the upper byte on its output bus and the other places the lower byte on its own output bus. A bus whose enable is high is released to high impedance, and a per-byte drive flag shows this. A 2-bit precision code sets how many of the top bits are meaningful. The bits below that point read as zero on the bus.

Top module: `angle_bus_latch`

## Requirements
- R1: While `hold_n` is high at a rising clock edge, the held word takes the value of `count_in` present at that edge. It is visible on the byte buses from that edge on, so the lag is one cycle.
- R2: While `hold_n` is low at a rising edge, the held word does not change. A hold freezes the word captured at the last edge where `hold_n` was high.
- R3: The counter input is never blocked by a hold. At the first edge with `hold_n` high after a hold, the held word becomes the counter value present at that edge, including any counter changes made during the hold.
- R4: While `upper_en_n` is low, `upper_oe` is 1 and `upper_bus` carries held-word bits 15..8. Bit 15 is the most significant bit and weighs half a turn (180 degrees) in natural binary.
- R5: While `lower_en_n` is low, `lower_oe` is 1 and `lower_bus` carries held-word bits 7..0.
- R6: While an enable is high, the drive flag of its byte is 0 and that byte bus is high impedance. The two enables act independently.
- R7: `prec_sel` values 0, 1, 2 and 3 keep the top 10, 12, 14 and 16 bits of the held word. All lower bits read 0 on the buses. A change of `prec_sel` affects the buses at once, with no clock.
- R8: While `rst_n` is low, the held word is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_in | input | 16 | Tracking angle counter value |
| hold_n | input | 1 | Active-low hold of the output word |
| upper_en_n | input | 1 | Active-low enable for the upper byte |
| lower_en_n | input | 1 | Active-low enable for the lower byte |
| prec_sel | input | 2 | Precision code: 10, 12, 14 or 16 bits |
| upper_bus | output | 8 | Upper byte, tri-state |
| lower_bus | output | 8 | Lower byte, tri-state |
| upper_oe | output | 1 | Upper byte is being driven |
| lower_oe | output | 1 | Lower byte is being driven |

## Verification
The counter is driven as an upward ramp, as a downward ramp and as random jumps. The ramps show the one-cycle lag of the register; the random jumps separate per-bit errors in the byte mapping. Holds of several lengths are applied while the counter keeps moving. A stuck or leaky hold shows up as a word change during the hold. A register that misses the release shows up as a stale word afterwards. Each precision code is then tried with both enables in all four combinations. This separates masking errors from byte-swap and enable-swap errors.

// File: rtl/angle_bus_latch.sv
module angle_bus_latch #(
  parameter int ANGLE_W = 16,
  parameter int BYTE_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ANGLE_W-1:0] count_in,
  input  logic               hold_n,
  input  logic               upper_en_n,
  input  logic               lower_en_n,
  input  logic [1:0]         prec_sel,
  output logic [BYTE_W-1:0]  upper_bus,
  output logic [BYTE_W-1:0]  lower_bus,
  output logic               upper_oe,
  output logic               lower_oe
);
  localparam int MIN_KEEP = ANGLE_W - 6;

  logic [ANGLE_W-1:0] held_q;
  logic [ANGLE_W-1:0] keep_mask;
  logic [ANGLE_W-1:0] shown;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= '0;
    else if (hold_n) held_q <= count_in;
  end

  always_comb begin
    for (int i = 0; i < ANGLE_W; i++)
      keep_mask[i] = (i >= ANGLE_W - (MIN_KEEP + 2 * int'(prec_sel)));
  end

  assign shown     = held_q & keep_mask;
  assign upper_oe  = !upper_en_n;
  assign lower_oe  = !lower_en_n;
  assign upper_bus = upper_oe ? shown[ANGLE_W-1 -: BYTE_W] : 'z;
  assign lower_bus = lower_oe ? shown[BYTE_W-1:0] : 'z;

  assert_track_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hold_n |=> held_q == $past(count_in));

  assert_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |=> $stable(held_q));

  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(hold_n) && hold_n) |=> held_q == $past(count_in));

  assert_upper_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !upper_en_n |-> upper_oe);

  assert_lower_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lower_en_n |-> lower_oe);

  assert_release_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upper_en_n |-> !upper_oe) and (lower_en_n |-> !lower_oe));

  assert_coarse_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prec_sel == 2'd0) |-> (shown[5:0] == '0 && shown[ANGLE_W-1:6] == held_q[ANGLE_W-1:6]));

  assert_full_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prec_sel == 2'd3) |-> shown == held_q);

  always @(posedge clk)
    if (!rst_n) assert_reset_R8: assert (held_q == '0);
endmodule

// File: tb/sim_angle_bus_latch.sv
module sim_angle_bus_latch;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] count_in = 0;
  logic        hold_n = 1;
  logic        upper_en_n = 1;
  logic        lower_en_n = 1;
  logic [1:0]  prec_sel = 2'd3;
  logic [7:0]  upper_bus, lower_bus;
  logic        upper_oe, lower_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string phase = "R1";
  logic [15:0] model_word = 0;

  always #5 clk = ~clk;

  angle_bus_latch u0 (
    .clk(clk), .rst_n(rst_n), .count_in(count_in), .hold_n(hold_n),
    .upper_en_n(upper_en_n), .lower_en_n(lower_en_n), .prec_sel(prec_sel),
    .upper_bus(upper_bus), .lower_bus(lower_bus),
    .upper_oe(upper_oe), .lower_oe(lower_oe)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] masked(logic [15:0] w, logic [1:0] p);
    int drop = 6 - 2 * p;
    return (w >> drop) << drop;
  endfunction

  task automatic compare();
    logic [15:0] m = masked(model_word, prec_sel);
    check(upper_en_n ? "R6 upper_oe" : "R4 upper_oe", {15'd0, upper_oe}, {15'd0, !upper_en_n});
    check(lower_en_n ? "R6 lower_oe" : "R5 lower_oe", {15'd0, lower_oe}, {15'd0, !lower_en_n});
    if (!upper_en_n) check({phase, "/R4 upper byte"}, {8'd0, upper_bus}, {8'd0, m[15:8]});
    if (!lower_en_n) check({phase, "/R5 lower byte"}, {8'd0, lower_bus}, {8'd0, m[7:0]});
  endtask

  task automatic step(logic [15:0] cnt, logic h, logic ue, logic le, logic [1:0] p);
    count_in = cnt; hold_n = h; upper_en_n = ue; lower_en_n = le; prec_sel = p;
    @(posedge clk);
    if (h) model_word = cnt;
    @(negedge clk);
    compare();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] c = 16'h1234;
    upper_en_n = 0; lower_en_n = 0; count_in = 16'hBEEF;
    repeat (2) @(negedge clk);
    phase = "R8";
    check("R8 reset upper", {8'd0, upper_bus}, 16'h0000);
    check("R8 reset lower", {8'd0, lower_bus}, 16'h0000);
    rst_n = 1;

    phase = "R1";
    for (int i = 0; i < 40; i++) begin c = c + 16'd37; step(c, 1, 0, 0, 2'd3); end
    for (int i = 0; i < 40; i++) begin c = c - 16'd251; step(c, 1, 0, 0, 2'd3); end

    for (int k = 0; k < 20; k++) begin
      int len = 1 + (k % 7);
      phase = "R1";
      for (int i = 0; i < 3; i++) begin c = c + 16'd3; step(c, 1, 0, 0, 2'd3); end
      phase = "R2";
      for (int i = 0; i < len; i++) begin c = c + 16'd113; step(c, 0, 0, 0, 2'd3); end
      phase = "R3";
      c = c + 16'd5;
      step(c, 1, 0, 0, 2'd3);
      check("R3 release word", {upper_bus, lower_bus}, c);
    end

    phase = "R7";
    for (int p = 0; p < 4; p++) begin
      for (int e = 0; e < 4; e++) begin
        for (int i = 0; i < 10; i++) begin
          c = 16'($urandom);
          step(c, 1, e[0], e[1], 2'(p));
        end
      end
    end

    phase = "R7";
    step(16'hFFFF, 1, 0, 0, 2'd3);
    step(16'h0000, 0, 0, 0, 2'd0);
    check("R7 ten bit all ones", {upper_bus, lower_bus}, 16'hFFC0);
    step(16'h0000, 0, 0, 0, 2'd1);
    check("R7 twelve bit all ones", {upper_bus, lower_bus}, 16'hFFF0);
    step(16'h0000, 0, 0, 0, 2'd2);
    check("R7 fourteen bit all ones", {upper_bus, lower_bus}, 16'hFFFC);
    phase = "R4";
    step(16'h8000, 1, 0, 1, 2'd3);
    check("R4 half turn msb", {8'd0, upper_bus}, 16'h0080);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule